// File: doc/BRIEF.md
# Prescaled Match Timer Channel

This block is one 16-bit timer-counter channel. A power-of-two prescaler sets how often the counter moves, and the counter steps up or down on each prescaled tick. It either runs free across the full 16-bit range, or restarts at a programmed interval limit. Three comparators watch the count. Each one raises its own status flag. Two more flags mark a wrap, one in interval mode and one in free-run mode. Status flags gather until software reads them. A single interrupt line is driven high while any flag that has its enable bit set is high.

The counter-control register lives inside the block and is written with a strobe. That register holds the halt bit, the interval-mode bit, the down-count bit, the match-enable bit and one spare bit. A write that has the clear bit set zeroes the count and restarts the prescaler phase. The clear bit is not stored. The clock control, the interval, the match values and the interrupt enables are level inputs. A pulse on `status_rd` stands for a read of the status register, and that read clears the flags.

The run logic is a two-state machine. `CS_HALT` is the reset state, and in it the count holds. `CS_RUN` lets the count advance. A counter-control write with bit 0 low takes the transition `go`, from `CS_HALT` to `CS_RUN`. A write with bit 0 high takes the transition `stop`, from `CS_RUN` to `CS_HALT`. Any other cycle leaves the state where it is.

Top module: `ptm_channel`

## Requirements
- R1: After reset, count is 0, status is 0, irq is 0, and `ctrl_q` reads 0x21 (halt bit 0 set, spare bit 5 set), so the counter starts halted.
- R2: While counter-control bit 0 (halt) is set, the count and the prescaler hold. The count does not change until a write clears the halt bit.
- R3: A counter-control write stores bits 5, 3, 2, 1 and 0. Bit 4 is never stored and reads as 0. When bit 4 is set in the written data, the count and the prescaler phase become 0 at that edge, and no step takes place in that cycle.
- R4: With clock-control bit 0 clear, the counter steps on every clock. With bit 0 set and N in bits 4:1, it steps once every 2^(N+1) clocks.
- R5: Counting up, the counter goes from 0xFFFF to 0 in free-run mode. In interval mode (counter-control bit 1), a step from any count at or above `interval` goes to 0, so the counter covers 0 through `interval`.
- R6: Counting down (counter-control bit 2), a step from 0 reloads 0xFFFF in free-run mode, or `interval` in interval mode. Any other step subtracts 1.
- R7: Every wrap of R5 or R6 sets status bit 0 in interval mode and status bit 4 in free-run mode.
- R8: With match enable (counter-control bit 3) set, a step that makes the count equal to match value k sets status bit k+1.
- R9: A match value above the current top (`interval` in interval mode) sets no flag, even when a down count passes through that value.
- R10: With match enable clear, no match flag is set.
- R11: Status bits stay set until a `status_rd` pulse, and that pulse clears all of them. A flag set on the same edge as the clear remains set.
- R12: irq is high exactly when (status AND irq_en) is nonzero. Status bit 5 is reserved and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_ctrl | input | 5 | Bit 0 enables the prescaler; bits 4:1 hold N |
| ctl_wr | input | 1 | Write strobe for the counter-control register |
| ctl_wdata | input | 6 | Counter-control write data: bit 0 halt, bit 1 interval mode, bit 2 down, bit 3 match enable, bit 4 clear, bit 5 spare |
| interval | input | 16 | Interval limit (top of the count) |
| match_val | input | 3x16 | Three match values, entry k at bits 16k+15:16k |
| irq_en | input | 6 | Interrupt enable per status bit |
| status_rd | input | 1 | Read-and-clear pulse for the status flags |
| count | output | 16 | Current count |
| ctrl_q | output | 6 | Counter-control read-back (bit 4 always 0) |
| status | output | 6 | Status flags: 0 interval wrap, 1..3 match, 4 overflow, 5 reserved |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions check on every cycle that a halted counter holds, that a clear write zeroes the count, that bit 4 of the read-back stays low, and that with the prescaler off the count moves by one or wraps on every clock. They also check that flags never drop without a read and that the reserved flag stays low. The reference model compares count, flags, interrupt and read-back on every clock. Only the bench's scenarios can show the prescaled step rate, the reload values in both directions, which wrap flag each mode raises, a match value that a down count passes while it is above the interval, and a flag set on the same edge as the read that clears the status.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
    localparam int CTL_W = 6;
    localparam int CTL_HALT = 0;
    localparam int CTL_INTV = 1;
    localparam int CTL_DOWN = 2;
    localparam int CTL_MEN  = 3;
    localparam int CTL_CLR  = 4;
    localparam int CTL_SPARE = 5;
    localparam logic [CTL_W-1:0] CTL_RESET_VAL = 6'h21;

    localparam int SB_W    = 6;
    localparam int SB_INTV = 0;
    localparam int SB_OVF  = 4;

    typedef enum logic {
        CS_HALT = 1'b0,
        CS_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/ptm_prescale.sv
module ptm_prescale #(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             ps_en,
    input  logic [EXP_W-1:0] ps_exp,
    output logic             tick
);
    localparam int PC_W = 1 << EXP_W;

    logic [PC_W-1:0]  pcnt_q;
    logic [PC_W-1:0]  span;
    logic [PC_W-1:0]  mask;
    logic [EXP_W:0]   shamt;
    logic [PC_W-1:0]  one_v;

    // Terminal phase is 2^(N+1)-1; a shift of PC_W gives zero, so mask wraps to all ones.
    always_comb begin
        one_v = '0;
        one_v[0] = 1'b1;
        shamt = {1'b0, ps_exp} + 1'b1;
        span  = one_v << shamt;
        mask  = ps_en ? (span - 1'b1) : '0;
        tick  = run && (pcnt_q >= mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (restart || tick) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ptm_counter.sv
module ptm_counter
    import ptm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic [CNT_W-1:0] interval,
    input  logic             tick,
    output logic             run,
    output logic             clr,
    output logic             step,
    output logic             match_en,
    output logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] nxt,
    output logic             wrap_intv,
    output logic             wrap_ovf,
    output logic [CNT_W-1:0] count,
    output logic [CTL_W-1:0] ctrl_q
);
    run_state_e       state_q, state_d;
    logic             intv_q, down_q, men_q, spare_q;
    logic [CNT_W-1:0] count_q;
    logic             at_wrap;

    // Run-state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: go (HALT->RUN), stop (RUN->HALT)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_HALT: if (ctl_wr && !ctl_wdata[CTL_HALT]) state_d = CS_RUN;
            CS_RUN:  if (ctl_wr &&  ctl_wdata[CTL_HALT]) state_d = CS_HALT;
        endcase
    end

    // Mode bits of the control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            intv_q  <= CTL_RESET_VAL[CTL_INTV];
            down_q  <= CTL_RESET_VAL[CTL_DOWN];
            men_q   <= CTL_RESET_VAL[CTL_MEN];
            spare_q <= CTL_RESET_VAL[CTL_SPARE];
        end else if (ctl_wr) begin
            intv_q  <= ctl_wdata[CTL_INTV];
            down_q  <= ctl_wdata[CTL_DOWN];
            men_q   <= ctl_wdata[CTL_MEN];
            spare_q <= ctl_wdata[CTL_SPARE];
        end
    end

    // Output / datapath decode
    always_comb begin
        run      = (state_q == CS_RUN);
        clr      = ctl_wr && ctl_wdata[CTL_CLR];
        step     = tick && !clr;
        match_en = men_q;
        top      = intv_q ? interval : {CNT_W{1'b1}};
        if (down_q) begin
            at_wrap = (count_q == '0);
            nxt     = at_wrap ? top : count_q - 1'b1;
        end else begin
            at_wrap = (count_q >= top);
            nxt     = at_wrap ? '0 : count_q + 1'b1;
        end
        wrap_intv = step && at_wrap && intv_q;
        wrap_ovf  = step && at_wrap && !intv_q;
        count     = count_q;
        ctrl_q    = '0;
        ctrl_q[CTL_HALT]  = (state_q == CS_HALT);
        ctrl_q[CTL_INTV]  = intv_q;
        ctrl_q[CTL_DOWN]  = down_q;
        ctrl_q[CTL_MEN]   = men_q;
        ctrl_q[CTL_SPARE] = spare_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else if (step) begin
            count_q <= nxt;
        end
    end
endmodule

// File: rtl/ptm_match.sv
module ptm_match #(
    parameter int CNT_W = 16,
    parameter int NUM_M = 3
) (
    input  logic                        step,
    input  logic                        en,
    input  logic [CNT_W-1:0]            top,
    input  logic [CNT_W-1:0]            nxt,
    input  logic [NUM_M-1:0][CNT_W-1:0] mvals,
    output logic [NUM_M-1:0]            hit
);
    for (genvar k = 0; k < NUM_M; k++) begin : g_cmp
        // Values beyond the current top are ignored
        assign hit[k] = step && en && (mvals[k] <= top) && (nxt == mvals[k]);
    end
endmodule

// File: rtl/ptm_status.sv
module ptm_status
    import ptm_pkg::*;
#(
    parameter int NUM_M = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd,
    input  logic            wrap_intv,
    input  logic            wrap_ovf,
    input  logic [NUM_M-1:0] hit,
    input  logic [SB_W-1:0] irq_en,
    output logic [SB_W-1:0] status,
    output logic            irq
);
    localparam int LIVE_W = SB_W - 1;

    logic [LIVE_W-1:0] flags_q;
    logic [LIVE_W-1:0] set_v;

    always_comb begin
        set_v = '0;
        set_v[SB_INTV]   = wrap_intv;
        set_v[NUM_M:1]   = hit;
        set_v[SB_OVF]    = wrap_ovf;
    end

    // New events win over a simultaneous read-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (rd ? '0 : flags_q) | set_v;
        end
    end

    always_comb begin
        status = {1'b0, flags_q};
        irq    = |(status & irq_en);
    end
endmodule

// File: rtl/ptm_channel.sv
module ptm_channel
    import ptm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int EXP_W = 4,
    parameter int NUM_M = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [EXP_W:0]              clk_ctrl,
    input  logic                        ctl_wr,
    input  logic [CTL_W-1:0]            ctl_wdata,
    input  logic [CNT_W-1:0]            interval,
    input  logic [NUM_M-1:0][CNT_W-1:0] match_val,
    input  logic [SB_W-1:0]             irq_en,
    input  logic                        status_rd,
    output logic [CNT_W-1:0]            count,
    output logic [CTL_W-1:0]            ctrl_q,
    output logic [SB_W-1:0]             status,
    output logic                        irq
);
    logic             run, clr, step, tick, match_en, wrap_intv, wrap_ovf;
    logic [CNT_W-1:0] top, nxt;
    logic [NUM_M-1:0] hit;

    ptm_prescale #(.EXP_W(EXP_W)) u_ps (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (clr || !run),
        .ps_en   (clk_ctrl[0]),
        .ps_exp  (clk_ctrl[EXP_W:1]),
        .tick    (tick)
    );

    ptm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .interval  (interval),
        .tick      (tick),
        .run       (run),
        .clr       (clr),
        .step      (step),
        .match_en  (match_en),
        .top       (top),
        .nxt       (nxt),
        .wrap_intv (wrap_intv),
        .wrap_ovf  (wrap_ovf),
        .count     (count),
        .ctrl_q    (ctrl_q)
    );

    ptm_match #(.CNT_W(CNT_W), .NUM_M(NUM_M)) u_match (
        .step  (step),
        .en    (match_en),
        .top   (top),
        .nxt   (nxt),
        .mvals (match_val),
        .hit   (hit)
    );

    ptm_status #(.NUM_M(NUM_M)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (status_rd),
        .wrap_intv (wrap_intv),
        .wrap_ovf  (wrap_ovf),
        .hit       (hit),
        .irq_en    (irq_en),
        .status    (status),
        .irq       (irq)
    );
endmodule

// File: rtl/ptm_channel_chk.sv
module ptm_channel_chk #(
    parameter int CNT_W = 16,
    parameter int EXP_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [EXP_W:0]   clk_ctrl,
    input logic             ctl_wr,
    input logic [5:0]       ctl_wdata,
    input logic             status_rd,
    input logic [CNT_W-1:0] count,
    input logic [5:0]       ctrl_q,
    input logic [5:0]       status
);
    assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[0] && !ctl_wr) |=> $stable(count));

    assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata[4]) |=> (count == '0));

    assert_clear_bit_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[4] == 1'b0);

    assert_fast_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr && !ctrl_q[0] && !ctrl_q[2] && !clk_ctrl[0])
        |=> ((count == CNT_W'($past(count) + 1'b1)) || (count == '0)));

    assert_flags_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !status_rd |=> ((status & $past(status)) == $past(status)));

    assert_rsvd_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        status[5] == 1'b0);
endmodule

bind ptm_channel ptm_channel_chk #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_ctrl  (clk_ctrl),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .status_rd (status_rd),
    .count     (count),
    .ctrl_q    (ctrl_q),
    .status    (status)
);

// File: tb/ptm_channel_tb.sv
module ptm_channel_tb_top;
    localparam int CLK_P = 10;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [4:0]      clk_ctrl;
    logic            ctl_wr;
    logic [5:0]      ctl_wdata;
    logic [15:0]     interval;
    logic [2:0][15:0] match_val;
    logic [5:0]      irq_en;
    logic            status_rd;
    logic [15:0]     count;
    logic [5:0]      ctrl_q;
    logic [5:0]      status;
    logic            irq;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit done = 0;

    int m_cnt, m_pc, m_st, m_ctl;

    ptm_channel dut_i (
        .clk(clk), .rst_n(rst_n), .clk_ctrl(clk_ctrl), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .interval(interval), .match_val(match_val),
        .irq_en(irq_en), .status_rd(status_rd), .count(count),
        .ctrl_q(ctrl_q), .status(status), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Behavioural reference, one update per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_pc = 0; m_st = 0; m_ctl = 'h21;
        end else begin
            int top, mask, nxt, set;
            bit run, tick, wrap;
            run  = (m_ctl & 1) == 0;
            top  = (m_ctl & 2) ? int'(interval) : 65535;
            mask = clk_ctrl[0] ? ((1 << (int'(clk_ctrl[4:1]) + 1)) - 1) : 0;
            tick = run && (m_pc >= mask);
            set  = 0;
            if (ctl_wr && ctl_wdata[4]) begin
                m_cnt = 0; m_pc = 0;
            end else begin
                m_pc = (!run || tick) ? 0 : m_pc + 1;
                if (tick) begin
                    if (m_ctl & 4) begin
                        wrap = (m_cnt == 0);
                        nxt  = wrap ? top : m_cnt - 1;
                    end else begin
                        wrap = (m_cnt >= top);
                        nxt  = wrap ? 0 : m_cnt + 1;
                    end
                    if (wrap) set |= (m_ctl & 2) ? 1 : 16;
                    if (m_ctl & 8)
                        for (int k = 0; k < 3; k++)
                            if (int'(match_val[k]) <= top && nxt == int'(match_val[k]))
                                set |= (2 << k);
                    m_cnt = nxt;
                end
            end
            m_st = (status_rd ? 0 : m_st) | set;
            if (ctl_wr) m_ctl = int'(ctl_wdata) & 'h2F;
        end
    end

    // Per-cycle comparison, a quarter period after the edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (rst_n && !done) begin
            check("R5 count vs model", int'(count), m_cnt);
            check("R7 status vs model", int'(status), m_st);
            check("R12 irq vs model", int'(irq), int'((m_st & int'(irq_en)) != 0));
            check("R3 ctrl readback vs model", int'(ctrl_q), m_ctl);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 200000);
            finish_run();
        end
    end

    task automatic wr_ctl(input logic [5:0] v);
        ctl_wdata = v; ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic rd_pulse();
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; clk_ctrl = '0; ctl_wr = 1'b0; ctl_wdata = '0;
        interval = '0; match_val = '0; irq_en = '0; status_rd = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset count", int'(count), 0);
        check("R1 reset ctrl", int'(ctrl_q), 'h21);
        check("R1 reset status", int'(status), 0);
        check("R1 reset irq", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Free run up, no prescale, matches on
        irq_en = 6'h3F;
        match_val[0] = 16'd5; match_val[1] = 16'd10; match_val[2] = 16'd20;
        wr_ctl(6'h18);
        repeat (10) @(negedge clk);
        check("R4 every clock", int'(count), 10);
        check("R8 matches 5 and 10", int'(status), 'h06);
        check("R12 irq enabled", int'(irq), 1);

        // Halt
        wr_ctl(6'h09);
        repeat (5) @(negedge clk);
        check("R2 halted hold", int'(count), 11);
        rd_pulse();
        check("R11 read clears", int'(status), 0);

        // Set on the same edge as clear
        wr_ctl(6'h18);
        repeat (4) @(negedge clk);
        rd_pulse();
        check("R11 set wins", int'(status), 'h02);
        check("R3 bit4 reads zero", int'(ctrl_q), 'h08);

        // Match disabled
        rd_pulse();
        wr_ctl(6'h10);
        repeat (12) @(negedge clk);
        check("R10 no match flags", int'(status), 0);

        // Interval up
        rd_pulse();
        interval = 16'd7;
        match_val[0] = 16'd3; match_val[1] = 16'd9; match_val[2] = 16'd7;
        wr_ctl(6'h1A);
        repeat (20) @(negedge clk);
        check("R5 interval wrap", int'(count), 4);
        check("R7 interval flag with R8 matches", int'(status), 'h0B);

        // Interval down, interval lowered below count
        rd_pulse();
        interval = 16'd20;
        match_val[0] = 16'd30; match_val[1] = 16'd12; match_val[2] = 16'd9;
        wr_ctl(6'h1E);
        repeat (6) @(negedge clk);
        check("R6 down reload", int'(count), 15);
        interval = 16'd10;
        repeat (6) @(negedge clk);
        check("R6 down step", int'(count), 9);
        check("R9 match above top ignored", int'(status), 'h09);
        repeat (10) @(negedge clk);
        check("R6 reload interval", int'(count), 10);

        // Prescaler
        rd_pulse();
        clk_ctrl = 5'b00101;
        wr_ctl(6'h10);
        repeat (20) @(negedge clk);
        check("R4 prescale N=2", int'(count), 2);
        clk_ctrl = 5'b00001;
        wr_ctl(6'h10);
        repeat (10) @(negedge clk);
        check("R4 prescale N=0", int'(count), 5);

        // Free-run overflow
        clk_ctrl = '0;
        wr_ctl(6'h10);
        rd_pulse();
        repeat (65535) @(negedge clk);
        check("R5 free-run wrap", int'(count), 0);
        check("R7 overflow flag", int'(status), 'h10);
        irq_en = 6'h01; #1;
        check("R12 masked", int'(irq), 0);
        irq_en = 6'h10; #1;
        check("R12 unmasked", int'(irq), 1);
        @(negedge clk);

        // Free-run down
        rd_pulse();
        wr_ctl(6'h14);
        repeat (3) @(negedge clk);
        check("R6 down from zero", int'(count), 'hFFFD);
        check("R7 down overflow flag", int'(status), 'h10);

        // Clear while halted
        wr_ctl(6'h01);
        repeat (3) @(negedge clk);
        check("R2 halt after down", int'(count), 'hFFFC);
        wr_ctl(6'h11);
        check("R3 clear count", int'(count), 0);
        check("R3 clear not stored", int'(ctrl_q), 'h01);
        wr_ctl(6'h31);
        check("R3 spare stored", int'(ctrl_q), 'h21);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule